// File: doc/BRIEF.md
# Line-Cycle Energy Accumulator

This block integrates energy for a three-phase supply. On every valid sample it forms nine terms: active energy (instantaneous voltage times current), reactive energy (voltage times the 90-degree shifted current) and apparent energy (rms voltage times rms current), one of each per phase. Each term is added into its own 32-bit signed accumulator. A 2-bit wiring code changes only the phase B terms. It covers supplies where phase B voltage is not measured and has to be rebuilt from phases A and C, or where phase B is absent.

Each of the three energy groups can run in one of two modes. In free-running mode the accumulators sum without end. In line-cycle mode the block counts zero-crossing pulses from the phases chosen by a mask. When the count reaches a programmed target, the sums are captured into readable holding registers, the running sums restart from zero and a done pulse is raised.

Software reads results through an addressed read port. The port can clear an accumulator as it reads it. It also returns a sticky wrap flag for that accumulator.

Top module: `line_energy_acc`

## Requirements
- R1: A read with `rd_en_i` high returns, on `rd_data_o` one cycle later together with `rd_valid_o`, the value at `rd_addr_i`. Address map: 0..2 active A/B/C, 3..5 reactive A/B/C, 6..8 apparent A/B/C. Any other address returns 0. In free-running mode the value is the running sum, which grows by the term on every cycle with `smp_valid_i` high.
- R2: Wiring code (`cfg_wiring_i`) sets the phase B active and reactive terms: 00 uses vb; 01 makes both terms zero; 10 uses vb = -(va+vc); 11 uses vb = -va. Phase A and C terms are identical under all codes.
- R3: The apparent term is rms voltage times rms current, both unsigned. Phase B adds zero under wiring code 01 and its own product under every other code.
- R4: After reset all accumulators read 0, `done_o` and `rd_valid_o` are 0, all mode bits are 0 (free-running), the crossing mask is 111, clear-on-read is 1, the wiring code is 00 and the crossing target is `ZC_DEFAULT`. A configuration write with `cfg_we_i` high takes effect on the next cycle.
- R5: While clear-on-read is set, a read returns the value and zeroes that accumulator. While it is clear, reads leave the value unchanged.
- R6: While all three line-mode bits are 1, clear-on-read has no effect, whatever its programmed value.
- R7: In line-cycle mode, each masked crossing pulse adds one to the count, and several phases in the same cycle add several. On the cycle the count reaches the target, the captured value is the running sum including that cycle's sample, and the running sum and count restart from zero. `done_o` is high for exactly the next cycle. Reads of a line-mode group return the captured value, and a clearing read zeroes the captured value.
- R8: The mode bits (bit0 active, bit1 reactive, bit2 apparent) act per group. A group in free-running mode keeps accumulating across a period end. With no line-mode bit set, `done_o` stays 0.
- R9: Accumulators wrap modulo 2^32. A wrap sets that accumulator's sticky flag, which is returned on `rd_ovf_o` with the read and cleared by any read of that accumulator.
- R10: A read in the same cycle as a sample returns the value from before that sample. With clear-on-read set, the accumulator then holds only the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load all configuration fields |
| cfg_line_mode_i | input | 3 | Line-cycle mode per group: bit0 active, bit1 reactive, bit2 apparent |
| cfg_zx_mask_i | input | 3 | Phases whose crossings count (bit0 A, bit1 B, bit2 C) |
| cfg_rd_clr_i | input | 1 | Clear-on-read enable |
| cfg_wiring_i | input | 2 | Wiring code for phase B |
| cfg_zc_target_i | input | ZC_W | Crossing count per line-cycle period |
| smp_valid_i | input | 1 | Sample inputs are valid this cycle |
| va_i | input | SMP_W | Phase A instantaneous voltage, signed |
| vb_i | input | SMP_W | Phase B instantaneous voltage, signed |
| vc_i | input | SMP_W | Phase C instantaneous voltage, signed |
| ia_i | input | SMP_W | Phase A current, signed |
| ib_i | input | SMP_W | Phase B current, signed |
| ic_i | input | SMP_W | Phase C current, signed |
| qa_i | input | SMP_W | Phase A quadrature current, signed |
| qb_i | input | SMP_W | Phase B quadrature current, signed |
| qc_i | input | SMP_W | Phase C quadrature current, signed |
| va_rms_i | input | SMP_W | Phase A rms voltage |
| vb_rms_i | input | SMP_W | Phase B rms voltage |
| vc_rms_i | input | SMP_W | Phase C rms voltage |
| ia_rms_i | input | SMP_W | Phase A rms current |
| ib_rms_i | input | SMP_W | Phase B rms current |
| ic_rms_i | input | SMP_W | Phase C rms current |
| zx_i | input | 3 | Zero-crossing pulses, bit0 A, bit1 B, bit2 C |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 4 | Accumulator address |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | ACC_W | Read data |
| rd_ovf_o | output | 1 | Wrap flag of the accumulator read |
| done_o | output | 1 | Line-cycle period completed |

## Verification
One sample with distinct nonzero values on all three phases is applied under each of the four wiring codes. Only the phase B results may differ between codes, and each code's phase B value points to a single voltage source. Crossing patterns with one, two and three phases in the same cycle, under a full mask and a single-phase mask, check that the period ends at the right pulse and not one earlier or later. The captured value then shows whether the end-cycle sample was included. A long run of full-scale samples puts the wrap exactly between two sample counts. Reads placed on a sample cycle show whether the clear acts before or after the addition.

// File: rtl/lce_pkg.sv
package lce_pkg;
  localparam int NUM_PH  = 3;
  localparam int NUM_GRP = 3;
  localparam int NUM_ACC = NUM_PH * NUM_GRP;

  typedef enum logic [1:0] {
    WIRE_NORMAL = 2'b00,
    WIRE_B_OFF  = 2'b01,
    WIRE_B_SUM  = 2'b10,
    WIRE_B_NEGA = 2'b11
  } wiring_e;
endpackage

// File: rtl/lce_terms.sv
module lce_terms
  import lce_pkg::*;
#(
  parameter int SMP_W = 12,
  parameter int ACC_W = 32
) (
  input  wiring_e                 wiring_i,
  input  logic signed [SMP_W-1:0] va_i,
  input  logic signed [SMP_W-1:0] vb_i,
  input  logic signed [SMP_W-1:0] vc_i,
  input  logic signed [SMP_W-1:0] ia_i,
  input  logic signed [SMP_W-1:0] ib_i,
  input  logic signed [SMP_W-1:0] ic_i,
  input  logic signed [SMP_W-1:0] qa_i,
  input  logic signed [SMP_W-1:0] qb_i,
  input  logic signed [SMP_W-1:0] qc_i,
  input  logic [SMP_W-1:0]        va_rms_i,
  input  logic [SMP_W-1:0]        vb_rms_i,
  input  logic [SMP_W-1:0]        vc_rms_i,
  input  logic [SMP_W-1:0]        ia_rms_i,
  input  logic [SMP_W-1:0]        ib_rms_i,
  input  logic [SMP_W-1:0]        ic_rms_i,
  output logic [NUM_ACC-1:0][ACC_W-1:0] term_o
);
  localparam int VX_W   = SMP_W + 2;
  localparam int PROD_W = VX_W + SMP_W;

  logic signed [VX_W-1:0] va_x, vb_x, vc_x, vb_eff;
  logic                   b_off;

  assign va_x  = VX_W'(va_i);
  assign vb_x  = VX_W'(vb_i);
  assign vc_x  = VX_W'(vc_i);
  assign b_off = (wiring_i == WIRE_B_OFF);

  always_comb begin
    unique case (wiring_i)
      WIRE_B_SUM:  vb_eff = -(va_x + vc_x);
      WIRE_B_NEGA: vb_eff = -va_x;
      default:     vb_eff = vb_x;
    endcase
  end

  function automatic logic [ACC_W-1:0] mul_s(input logic signed [VX_W-1:0] v,
                                             input logic signed [SMP_W-1:0] c);
    logic signed [PROD_W-1:0] p;
    p = PROD_W'(v) * PROD_W'(c);
    return ACC_W'(p);
  endfunction

  function automatic logic [ACC_W-1:0] mul_u(input logic [SMP_W-1:0] r,
                                             input logic [SMP_W-1:0] c);
    return ACC_W'(r) * ACC_W'(c);
  endfunction

  always_comb begin
    term_o[0] = mul_s(va_x, ia_i);
    term_o[1] = b_off ? '0 : mul_s(vb_eff, ib_i);
    term_o[2] = mul_s(vc_x, ic_i);
    term_o[3] = mul_s(va_x, qa_i);
    term_o[4] = b_off ? '0 : mul_s(vb_eff, qb_i);
    term_o[5] = mul_s(vc_x, qc_i);
    term_o[6] = mul_u(va_rms_i, ia_rms_i);
    term_o[7] = b_off ? '0 : mul_u(vb_rms_i, ib_rms_i);
    term_o[8] = mul_u(vc_rms_i, ic_rms_i);
  end
endmodule

// File: rtl/lce_zc_timer.sv
module lce_zc_timer #(
  parameter int ZC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic [2:0]      zx_i,
  input  logic [2:0]      mask_i,
  input  logic [ZC_W-1:0] target_i,
  output logic            end_o,
  output logic            done_o
);
  logic [ZC_W-1:0] cnt_q;
  logic [1:0]      inc;
  logic [ZC_W:0]   sum;

  assign inc   = 2'($countones(zx_i & mask_i));
  assign sum   = {1'b0, cnt_q} + (ZC_W+1)'(inc);
  assign end_o = active_i && (inc != 2'd0) && (sum >= {1'b0, target_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= end_o;
      if (!active_i || end_o) cnt_q <= '0;
      else                    cnt_q <= sum[ZC_W-1:0];
    end
  end
endmodule

// File: rtl/lce_acc_cell.sv
module lce_acc_cell #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             add_i,
  input  logic [ACC_W-1:0] term_i,
  input  logic             line_i,
  input  logic             end_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [ACC_W-1:0] value_o,
  output logic             ovf_o
);
  logic [ACC_W-1:0] run_q, hold_q, base, addend, sum;
  logic             wrap, rd_clr;

  assign rd_clr = rd_i && clr_i;
  // a clearing read acts on the old value; the sample of the same cycle still lands
  assign base   = (rd_clr && !line_i) ? '0 : run_q;
  assign addend = add_i ? term_i : '0;
  assign sum    = base + addend;
  assign wrap   = add_i && (base[ACC_W-1] == addend[ACC_W-1]) &&
                  (sum[ACC_W-1] != base[ACC_W-1]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hold_q <= '0;
      ovf_o  <= 1'b0;
    end else begin
      ovf_o <= rd_i ? wrap : (ovf_o | wrap);
      if (line_i && end_i) begin
        run_q  <= '0;
        hold_q <= sum;
      end else begin
        run_q <= sum;
        if (rd_clr && line_i) hold_q <= '0;
      end
    end
  end

  assign value_o = line_i ? hold_q : run_q;
endmodule

// File: rtl/line_energy_acc.sv
module line_energy_acc
  import lce_pkg::*;
#(
  parameter int SMP_W      = 12,
  parameter int ACC_W      = 32,
  parameter int ZC_W       = 16,
  parameter int ZC_DEFAULT = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_line_mode_i,
  input  logic [2:0]       cfg_zx_mask_i,
  input  logic             cfg_rd_clr_i,
  input  logic [1:0]       cfg_wiring_i,
  input  logic [ZC_W-1:0]  cfg_zc_target_i,
  input  logic             smp_valid_i,
  input  logic signed [SMP_W-1:0] va_i,
  input  logic signed [SMP_W-1:0] vb_i,
  input  logic signed [SMP_W-1:0] vc_i,
  input  logic signed [SMP_W-1:0] ia_i,
  input  logic signed [SMP_W-1:0] ib_i,
  input  logic signed [SMP_W-1:0] ic_i,
  input  logic signed [SMP_W-1:0] qa_i,
  input  logic signed [SMP_W-1:0] qb_i,
  input  logic signed [SMP_W-1:0] qc_i,
  input  logic [SMP_W-1:0] va_rms_i,
  input  logic [SMP_W-1:0] vb_rms_i,
  input  logic [SMP_W-1:0] vc_rms_i,
  input  logic [SMP_W-1:0] ia_rms_i,
  input  logic [SMP_W-1:0] ib_rms_i,
  input  logic [SMP_W-1:0] ic_rms_i,
  input  logic [2:0]       zx_i,
  input  logic             rd_en_i,
  input  logic [3:0]       rd_addr_i,
  output logic             rd_valid_o,
  output logic [ACC_W-1:0] rd_data_o,
  output logic             rd_ovf_o,
  output logic             done_o
);
  logic [2:0]      cfg_line_q, cfg_zx_mask_q;
  logic            cfg_rd_clr_q, clr_eff, period_end;
  wiring_e         cfg_wiring_q;
  logic [ZC_W-1:0] cfg_target_q;

  logic [NUM_ACC-1:0][ACC_W-1:0] term;
  logic [ACC_W-1:0]  acc_val [NUM_ACC];
  logic [NUM_ACC-1:0] acc_ovf;
  logic [ACC_W-1:0]  rd_mux;
  logic              ovf_mux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_line_q    <= 3'b000;
      cfg_zx_mask_q <= 3'b111;
      cfg_rd_clr_q  <= 1'b1;
      cfg_wiring_q  <= WIRE_NORMAL;
      cfg_target_q  <= ZC_W'(ZC_DEFAULT);
    end else if (cfg_we_i) begin
      cfg_line_q    <= cfg_line_mode_i;
      cfg_zx_mask_q <= cfg_zx_mask_i;
      cfg_rd_clr_q  <= cfg_rd_clr_i;
      cfg_wiring_q  <= wiring_e'(cfg_wiring_i);
      cfg_target_q  <= cfg_zc_target_i;
    end
  end

  // clear-on-read is forced off while every group runs line-cycle
  assign clr_eff = cfg_rd_clr_q && !(&cfg_line_q);

  lce_terms #(.SMP_W(SMP_W), .ACC_W(ACC_W)) u_terms (
    .wiring_i(cfg_wiring_q),
    .va_i(va_i), .vb_i(vb_i), .vc_i(vc_i),
    .ia_i(ia_i), .ib_i(ib_i), .ic_i(ic_i),
    .qa_i(qa_i), .qb_i(qb_i), .qc_i(qc_i),
    .va_rms_i(va_rms_i), .vb_rms_i(vb_rms_i), .vc_rms_i(vc_rms_i),
    .ia_rms_i(ia_rms_i), .ib_rms_i(ib_rms_i), .ic_rms_i(ic_rms_i),
    .term_o(term)
  );

  lce_zc_timer #(.ZC_W(ZC_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .active_i(|cfg_line_q),
    .zx_i(zx_i), .mask_i(cfg_zx_mask_q), .target_i(cfg_target_q),
    .end_o(period_end), .done_o(done_o)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_acc
    localparam int GRP = i / NUM_PH;
    lce_acc_cell #(.ACC_W(ACC_W)) u_cell (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .add_i(smp_valid_i), .term_i(term[i]),
      .line_i(cfg_line_q[GRP]), .end_i(period_end),
      .rd_i(rd_en_i && (rd_addr_i == 4'(i))), .clr_i(clr_eff),
      .value_o(acc_val[i]), .ovf_o(acc_ovf[i])
    );
  end

  always_comb begin
    rd_mux  = '0;
    ovf_mux = 1'b0;
    for (int i = 0; i < NUM_ACC; i++) begin
      if (rd_addr_i == 4'(i)) begin
        rd_mux  = acc_val[i];
        ovf_mux = acc_ovf[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      rd_ovf_o   <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) begin
        rd_data_o <= rd_mux;
        rd_ovf_o  <= ovf_mux;
      end
    end
  end
endmodule

// File: rtl/line_energy_acc_chk.sv
module line_energy_acc_chk #(
  parameter int ACC_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_en_i,
  input logic [3:0]       rd_addr_i,
  input logic             rd_valid_o,
  input logic [ACC_W-1:0] rd_data_o,
  input logic             done_o,
  input logic [2:0]       zx_i,
  input logic [2:0]       zx_mask_i,
  input logic [2:0]       line_mode_i
);
  p_rd_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  p_rd_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  p_unmapped_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i > 4'd8) |=> (rd_data_o == '0));

  p_done_needs_zx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(|(zx_i & zx_mask_i)));

  p_regular_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_mode_i == 3'b000) |=> !done_o);
endmodule

bind line_energy_acc line_energy_acc_chk #(.ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
  .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .done_o(done_o),
  .zx_i(zx_i), .zx_mask_i(cfg_zx_mask_q), .line_mode_i(cfg_line_q)
);

// File: tb/line_energy_acc_test.sv
module line_energy_acc_test;
  localparam int SMP_W = 12;
  localparam int ACC_W = 32;
  localparam int ZC_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic cfg_we = 0, cfg_rd_clr = 1;
  logic [2:0] cfg_line = 0, cfg_mask = 3'b111;
  logic [1:0] cfg_wiring = 0;
  logic [ZC_W-1:0] cfg_target = 16'd100;
  logic smp_valid = 0;
  logic signed [SMP_W-1:0] va, vb, vc, ia, ib, ic, qa, qb, qc;
  logic [SMP_W-1:0] var_, vbr, vcr, iar, ibr, icr;
  logic [2:0] zx = 0;
  logic rd_en = 0;
  logic [3:0] rd_addr = 0;
  logic rd_valid, rd_ovf, done;
  logic [ACC_W-1:0] rd_data;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  line_energy_acc #(.SMP_W(SMP_W), .ACC_W(ACC_W), .ZC_W(ZC_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_line_mode_i(cfg_line), .cfg_zx_mask_i(cfg_mask),
    .cfg_rd_clr_i(cfg_rd_clr), .cfg_wiring_i(cfg_wiring), .cfg_zc_target_i(cfg_target),
    .smp_valid_i(smp_valid),
    .va_i(va), .vb_i(vb), .vc_i(vc), .ia_i(ia), .ib_i(ib), .ic_i(ic),
    .qa_i(qa), .qb_i(qb), .qc_i(qc),
    .va_rms_i(var_), .vb_rms_i(vbr), .vc_rms_i(vcr),
    .ia_rms_i(iar), .ib_rms_i(ibr), .ic_rms_i(icr),
    .zx_i(zx), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_ovf_o(rd_ovf), .done_o(done)
  );

  task automatic check(input string req, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, $signed(act), $signed(exp));
    end
  endtask

  task automatic base_inputs();
    va = 100; vb = -50; vc = 20; ia = 3; ib = 4; ic = -5;
    qa = 2; qb = -1; qc = 6;
    var_ = 10; vbr = 20; vcr = 30; iar = 1; ibr = 2; icr = 3;
  endtask

  task automatic step(input logic v, input logic [2:0] z, input logic r, input int a);
    @(negedge clk);
    smp_valid = v; zx = z; rd_en = r; rd_addr = 4'(a);
    @(posedge clk);
    #2 smp_valid = 0; zx = 0; rd_en = 0;
  endtask

  task automatic rd(input int a, output logic [ACC_W-1:0] d, output logic o);
    step(0, 3'b000, 1, a);
    @(negedge clk);
    d = rd_data; o = rd_ovf;
  endtask

  task automatic cfg(input logic [2:0] lm, input logic [2:0] m, input logic c,
                     input logic [1:0] w, input int t);
    @(negedge clk);
    cfg_we = 1; cfg_line = lm; cfg_mask = m; cfg_rd_clr = c; cfg_wiring = w;
    cfg_target = ZC_W'(t);
    @(posedge clk);
    #2 cfg_we = 0;
  endtask

  task automatic clear_all();
    logic [ACC_W-1:0] d; logic o;
    for (int a = 0; a < 9; a++) rd(a, d, o);
  endtask

  // R4 defaults after reset
  task automatic t_reset();
    logic [ACC_W-1:0] d; logic o;
    check("R4 done", 32'(done), 0);
    check("R4 rd_valid", 32'(rd_valid), 0);
    for (int a = 0; a < 9; a++) begin
      rd(a, d, o);
      check("R4 acc zero", d, 0);
    end
  endtask

  // R1/R2/R3/R5 with default wiring 00, default clear-on-read
  task automatic t_regular();
    logic [ACC_W-1:0] d; logic o;
    logic [ACC_W-1:0] exp [9];
    exp = '{600, -400, -200, 400, 100, 240, 20, 80, 180};
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    for (int a = 0; a < 9; a++) begin
      step(0, 0, 1, a);
      @(negedge clk);
      check("R1 rd_valid", 32'(rd_valid), 1);
      check("R1/R2/R3 wiring00 sum", rd_data, exp[a]);
    end
    rd(0, d, o);
    check("R5 cleared by read", d, 0);
    rd(12, d, o);
    check("R1 unmapped addr", d, 0);
  endtask

  task automatic t_wiring(input logic [1:0] w, input int eb_act, input int eb_react, input int eb_app);
    logic [ACC_W-1:0] d; logic o;
    cfg(3'b000, 3'b111, 1, w, 100);
    step(1, 0, 0, 0);
    rd(1, d, o); check("R2 phase B active", d, eb_act);
    rd(4, d, o); check("R2 phase B reactive", d, eb_react);
    rd(7, d, o); check("R3 phase B apparent", d, eb_app);
    rd(0, d, o); check("R2 phase A unaffected", d, 300);
    rd(5, d, o); check("R2 phase C unaffected", d, 120);
    clear_all();
  endtask

  task automatic t_no_clear();
    logic [ACC_W-1:0] d; logic o;
    cfg(3'b000, 3'b111, 0, 2'b00, 100);
    step(1, 0, 0, 0);
    rd(0, d, o); check("R5 no clear first", d, 300);
    rd(0, d, o); check("R5 no clear second", d, 300);
    cfg(3'b000, 3'b111, 1, 2'b00, 100);
    rd(0, d, o); check("R5 clear read value", d, 300);
    rd(0, d, o); check("R5 clear result", d, 0);
    clear_all();
  endtask

  task automatic t_line();
    logic [ACC_W-1:0] d; logic o;
    cfg(3'b001, 3'b111, 1, 2'b00, 4);
    step(1, 3'b001, 0, 0);
    step(1, 3'b011, 0, 0);
    @(negedge clk); check("R7 no early done", 32'(done), 0);
    step(1, 3'b100, 0, 0);
    @(negedge clk); check("R7 done pulse", 32'(done), 1);
    @(negedge clk); check("R7 done one cycle", 32'(done), 0);
    rd(0, d, o); check("R7 captured sum", d, 900);
    rd(0, d, o); check("R7 captured cleared", d, 0);
    rd(3, d, o); check("R8 regular group runs", d, 600);
    cfg(3'b001, 3'b001, 1, 2'b00, 2);
    step(1, 3'b111, 0, 0);
    @(negedge clk); check("R7 mask limits count", 32'(done), 0);
    step(1, 3'b001, 0, 0);
    @(negedge clk); check("R7 masked period end", 32'(done), 1);
    rd(0, d, o); check("R7 restart after end", d, 600);
  endtask

  task automatic t_all_line();
    logic [ACC_W-1:0] d; logic o;
    cfg(3'b111, 3'b111, 1, 2'b00, 1);
    step(1, 3'b001, 0, 0);
    rd(0, d, o); check("R6 first read", d, 300);
    rd(0, d, o); check("R6 clear suppressed", d, 300);
    rd(3, d, o); check("R8 reactive captured", d, 600);
    cfg(3'b000, 3'b111, 1, 2'b00, 100);
    rd(0, d, o); check("R7 running restarted", d, 0);
    clear_all();
  endtask

  task automatic t_wrap();
    logic [ACC_W-1:0] d; logic o;
    va = 2047; vb = 0; vc = 0; ia = 2047; ib = 0; ic = 0; qa = 0; qb = 0; qc = 0;
    var_ = 0; vbr = 0; vcr = 0; iar = 0; ibr = 0; icr = 0;
    cfg(3'b000, 3'b111, 0, 2'b00, 100);
    for (int k = 0; k < 512; k++) step(1, 0, 0, 0);
    rd(0, d, o);
    check("R9 pre-wrap value", d, 32'd2145387008);
    check("R9 pre-wrap flag", 32'(o), 0);
    step(1, 0, 0, 0);
    rd(0, d, o);
    check("R9 wrapped value", d, 32'(-2145390079));
    check("R9 wrap flag", 32'(o), 1);
    rd(0, d, o);
    check("R9 flag cleared by read", 32'(o), 0);
    cfg(3'b000, 3'b111, 1, 2'b00, 100);
    clear_all();
    base_inputs();
  endtask

  task automatic t_same_cycle();
    logic [ACC_W-1:0] d; logic o;
    step(1, 0, 0, 0);
    step(1, 0, 1, 0);
    @(negedge clk);
    check("R10 read returns old value", rd_data, 300);
    rd(0, d, o); check("R10 new sample kept", d, 300);
    rd(0, d, o); check("R10 then cleared", d, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    base_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regular();
    t_wiring(2'b01, 0, 0, 0);
    t_wiring(2'b10, -480, 120, 40);
    t_wiring(2'b11, -400, 100, 40);
    t_wiring(2'b00, -200, 50, 40);
    t_no_clear();
    t_line();
    t_all_line();
    t_wrap();
    t_same_cycle();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule